// File: doc/BRIEF.md
# Per-Port Forwarding Policy Filter

This block sits after the address lookup of an Ethernet switch and turns each lookup result into a final forwarding decision. It combines three things: the request (destination MAC, ingress port number, endpoint priority and a flag saying whether that priority is valid), the lookup outcome (hit or miss, the destination port mask and a broadcast mask), and a set of per-port control bits. From these it produces the final egress port mask, the frame priority, a drop flag and a one-cycle push strobe toward the software learning queue.

Each port has its own control bits. They select learning on a miss, the pass-all gate, a pass bit for the reserved bridge-control multicast address, a fixed priority with its 3-bit value, and whether a miss broadcasts or drops. A global enable overrides every per-port setting. The decision is registered. A request is accepted with a valid/ready pair, and the result is held on the output until the consumer takes it.

Top module: `port_policy_filter`

## Requirements
- R1: When `gen_i` is 0 at acceptance, the decision has `dec_drop_o`=1 and `dec_mask_o`=0, and `uq_push_o` stays 0, whatever the per-port bits and the lookup result are.
- R2: When the ingress port's pass bit (`cfg_pass_i[pid]`) is 0 and the destination is not the control address, the frame is dropped (drop=1, mask=0).
- R3: A frame whose destination equals 48'h0180C2000000 and whose port has `cfg_ctrl_pass_i[pid]`=1 follows the lookup result even when the pass bit is 0. With `cfg_ctrl_pass_i[pid]`=0 and pass bit 0, the frame is dropped.
- R4: On a hit (`lk_hit_i`=1) through an open gate, `dec_mask_o` equals `lk_mask_i` and `dec_drop_o`=0.
- R5: On a miss through an open gate, `cfg_miss_bcast_i[pid]`=1 gives mask = `lk_bcast_i` with bit `pid` cleared and drop=0. When that bit is 0, the result is drop=1 and mask=0.
- R6: On a miss through an open gate with `cfg_learn_i[pid]`=1 and `uq_full_i`=0 at acceptance, `uq_push_o` is 1 for exactly one cycle, namely the first cycle the decision is valid. When `uq_full_i`=1 no push is made and the mask/drop decision is unchanged.
- R7: With `cfg_fixprio_i[pid]`=1, `dec_prio_o` is `cfg_prioval_i[pid*3 +: 3]`. Otherwise it is `req_prio_i` when `req_prio_ok_i`=1, and 0 when that flag is 0.
- R8: A port ID of NPORTS or above is dropped with no push. Its priority follows the endpoint rule of R7 as if fix-priority were 0.
- R9: A request is accepted on a rising edge with `req_valid_i`=1 and `req_ready_o`=1, where `req_ready_o` = !`dec_valid_o` || `dec_ready_i`. The decision is valid from the next cycle and is held stable while `dec_ready_i`=0.
- R10: During and right after reset, `dec_valid_o`=0 and `uq_push_o`=0.
- R11: Control bits of ports other than the ingress port have no effect on the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be accepted |
| req_dmac_i | input | 48 | Destination MAC |
| req_pid_i | input | 4 | Ingress port number |
| req_prio_i | input | 3 | Endpoint priority |
| req_prio_ok_i | input | 1 | Endpoint priority valid |
| lk_hit_i | input | 1 | Lookup hit |
| lk_mask_i | input | NPORTS | Destination mask from lookup |
| lk_bcast_i | input | NPORTS | Broadcast mask |
| gen_i | input | 1 | Global enable |
| cfg_learn_i | input | NPORTS | Per-port learn on miss |
| cfg_pass_i | input | NPORTS | Per-port pass-all gate |
| cfg_ctrl_pass_i | input | NPORTS | Per-port pass for control address |
| cfg_fixprio_i | input | NPORTS | Per-port fixed-priority select |
| cfg_prioval_i | input | NPORTS*3 | Per-port fixed priority values |
| cfg_miss_bcast_i | input | NPORTS | Per-port miss action: 1 broadcast, 0 drop |
| uq_full_i | input | 1 | Learning queue full |
| dec_valid_o | output | 1 | Decision valid |
| dec_ready_i | input | 1 | Decision consumed |
| dec_mask_o | output | NPORTS | Final egress mask |
| dec_prio_o | output | 3 | Final priority |
| dec_drop_o | output | 1 | Frame dropped |
| uq_push_o | output | 1 | Learning queue push strobe |

## Verification
Every decision field and the push strobe are due in the cycle that follows the accepting rising edge. The bench therefore drives a request at a falling edge and reads the outputs at the next falling edge, half a cycle after the edge that registered them. In the stall test the same outputs are read again one and two falling edges later: they must be unchanged, and the push must have fallen after its single cycle. `req_ready_o` is combinational and is read in the same half cycle as the state it depends on.

// File: rtl/port_policy_filter.sv
module port_policy_filter #(
  parameter int NPORTS = 10,
  parameter int PID_W = 4,
  parameter int PRIO_W = 3,
  parameter int MAC_W = 48,
  parameter logic [MAC_W-1:0] CTRL_MAC = 48'h0180C2000000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic [MAC_W-1:0]         req_dmac_i,
  input  logic [PID_W-1:0]         req_pid_i,
  input  logic [PRIO_W-1:0]        req_prio_i,
  input  logic                     req_prio_ok_i,
  input  logic                     lk_hit_i,
  input  logic [NPORTS-1:0]        lk_mask_i,
  input  logic [NPORTS-1:0]        lk_bcast_i,
  input  logic                     gen_i,
  input  logic [NPORTS-1:0]        cfg_learn_i,
  input  logic [NPORTS-1:0]        cfg_pass_i,
  input  logic [NPORTS-1:0]        cfg_ctrl_pass_i,
  input  logic [NPORTS-1:0]        cfg_fixprio_i,
  input  logic [NPORTS*PRIO_W-1:0] cfg_prioval_i,
  input  logic [NPORTS-1:0]        cfg_miss_bcast_i,
  input  logic                     uq_full_i,
  output logic                     dec_valid_o,
  input  logic                     dec_ready_i,
  output logic [NPORTS-1:0]        dec_mask_o,
  output logic [PRIO_W-1:0]        dec_prio_o,
  output logic                     dec_drop_o,
  output logic                     uq_push_o
);
  localparam logic [PID_W:0] NP = NPORTS[PID_W:0];

  logic              accept, pid_ok, is_ctrl, gate, want_bc, push_n;
  logic [NPORTS-1:0] sel;
  logic [NPORTS-1:0] mask_n;
  logic              drop_n;
  logic [PRIO_W-1:0] fixv, prio_n;

  assign req_ready_o = !dec_valid_o || dec_ready_i;
  assign accept      = req_valid_i && req_ready_o;
  assign pid_ok      = {1'b0, req_pid_i} < NP;
  assign sel         = pid_ok ? (NPORTS'(1) << req_pid_i) : '0;
  assign is_ctrl     = req_dmac_i == CTRL_MAC;

  assign gate    = gen_i && |(sel & (cfg_pass_i | (is_ctrl ? cfg_ctrl_pass_i : '0)));
  assign want_bc = |(sel & cfg_miss_bcast_i);
  assign push_n  = gate && !lk_hit_i && |(sel & cfg_learn_i) && !uq_full_i;

  always_comb begin
    if (!gate) begin
      mask_n = '0;
      drop_n = 1'b1;
    end else if (lk_hit_i) begin
      mask_n = lk_mask_i;
      drop_n = 1'b0;
    end else if (want_bc) begin
      mask_n = lk_bcast_i & ~sel;
      drop_n = 1'b0;
    end else begin
      mask_n = '0;
      drop_n = 1'b1;
    end
  end

  always_comb begin
    fixv = '0;
    for (int i = 0; i < NPORTS; i++)
      if (sel[i]) fixv = cfg_prioval_i[i*PRIO_W +: PRIO_W];
  end

  assign prio_n = |(sel & cfg_fixprio_i) ? fixv
                : (req_prio_ok_i ? req_prio_i : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid_o <= 1'b0;
      dec_mask_o  <= '0;
      dec_prio_o  <= '0;
      dec_drop_o  <= 1'b0;
      uq_push_o   <= 1'b0;
    end else begin
      uq_push_o <= accept && push_n;
      if (accept) begin
        dec_valid_o <= 1'b1;
        dec_mask_o  <= mask_n;
        dec_prio_o  <= prio_n;
        dec_drop_o  <= drop_n;
      end else if (dec_ready_i) begin
        dec_valid_o <= 1'b0;
      end
    end
  end

  p_gdis_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !gen_i |=> dec_drop_o && !uq_push_o);

  p_drop_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_o && dec_drop_o |-> dec_mask_o == '0);

  p_no_push_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    uq_push_o |-> dec_valid_o && !$past(uq_full_i));

  p_bad_pid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && ({1'b0, req_pid_i} >= NP) |=> dec_drop_o && !uq_push_o);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_o && !dec_ready_i |=> dec_valid_o && $stable(dec_mask_o)
      && $stable(dec_drop_o) && $stable(dec_prio_o));
endmodule

// File: tb/tb_port_policy_filter.sv
`timescale 1ns/1ps
module tb_port_policy_filter;
  localparam int N = 10;
  localparam logic [47:0] CTRL = 48'h0180C2000000;
  localparam logic [47:0] UCAST = 48'h00163E123456;
  localparam logic [N-1:0] LKM = 10'h0A5;
  localparam logic [N-1:0] BCM = 10'h3FF;

  typedef struct packed {
    logic [3:0] pid;
    logic gen, ctrl, hit, learn, pass, cpass, fix, mbc, full, eok;
    logic [2:0] pval, eprio;
    logic [N-1:0] xmask;
    logic [2:0] xprio;
    logic xdrop, xpush;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    // pid gen ctl hit lrn pas cps fix mbc ful eok pval eprio | mask prio drop push
    '{4'd2, 1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 3'd5,3'd3, 10'h0A5,3'd3,1'b0,1'b0}, // R4 R7
    '{4'd2, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 3'd5,3'd3, 10'h000,3'd3,1'b1,1'b0}, // R1
    '{4'd3, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 3'd0,3'd6, 10'h000,3'd6,1'b1,1'b0}, // R2
    '{4'd3, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 3'd0,3'd6, 10'h0A5,3'd6,1'b0,1'b0}, // R3
    '{4'd3, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 3'd0,3'd6, 10'h000,3'd6,1'b1,1'b0}, // R3
    '{4'd4, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 3'd0,3'd7, 10'h3EF,3'd0,1'b0,1'b0}, // R5 R7
    '{4'd4, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd0,3'd7, 10'h000,3'd0,1'b1,1'b0}, // R5
    '{4'd0, 1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1, 3'd5,3'd1, 10'h000,3'd5,1'b1,1'b1}, // R6 R7
    '{4'd0, 1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1, 3'd2,3'd4, 10'h3FE,3'd2,1'b0,1'b0}, // R6 full
    '{4'd9, 1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1, 3'd0,3'd1, 10'h1FF,3'd1,1'b0,1'b1}, // R6 R5
    '{4'd10,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1, 3'd0,3'd2, 10'h000,3'd2,1'b1,1'b0}, // R8
    '{4'd1, 1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1, 3'd0,3'd2, 10'h000,3'd2,1'b1,1'b0}, // R1
    '{4'd9, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 3'd0,3'd5, 10'h0A5,3'd0,1'b0,1'b0}  // R3
  };

  logic clk = 0, rst_n = 0;
  logic req_valid_i = 0, req_ready_o, req_prio_ok_i = 0, lk_hit_i = 0, gen_i = 0;
  logic [47:0] req_dmac_i = '0;
  logic [3:0] req_pid_i = '0;
  logic [2:0] req_prio_i = '0;
  logic [N-1:0] lk_mask_i = LKM, lk_bcast_i = BCM;
  logic [N-1:0] cfg_learn_i = '0, cfg_pass_i = '0, cfg_ctrl_pass_i = '0;
  logic [N-1:0] cfg_fixprio_i = '0, cfg_miss_bcast_i = '0;
  logic [N*3-1:0] cfg_prioval_i = '0;
  logic uq_full_i = 0, dec_ready_i = 1;
  logic dec_valid_o, dec_drop_o, uq_push_o;
  logic [N-1:0] dec_mask_o;
  logic [2:0] dec_prio_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  port_policy_filter dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    for (int p = 0; p < N; p++) begin
      logic own;
      own = (p == int'(v.pid));
      cfg_learn_i[p]      = own ? v.learn : ~v.learn;
      cfg_pass_i[p]       = own ? v.pass  : ~v.pass;
      cfg_ctrl_pass_i[p]  = own ? v.cpass : ~v.cpass;
      cfg_fixprio_i[p]    = own ? v.fix   : ~v.fix;
      cfg_miss_bcast_i[p] = own ? v.mbc   : ~v.mbc;
      cfg_prioval_i[p*3 +: 3] = own ? v.pval : ~v.pval;
    end
    req_pid_i = v.pid; gen_i = v.gen; req_dmac_i = v.ctrl ? CTRL : UCAST;
    lk_hit_i = v.hit; uq_full_i = v.full; req_prio_ok_i = v.eok; req_prio_i = v.eprio;
    req_valid_i = 1;
  endtask

  initial begin
    #(8 * 5000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 valid in reset", dec_valid_o, 0);
    chk("R10 push in reset", uq_push_o, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R10 valid after reset", dec_valid_o, 0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      @(negedge clk);
      req_valid_i = 0;
      chk($sformatf("R9 R11 vec%0d valid", i), dec_valid_o, 1);
      chk($sformatf("R11 vec%0d mask", i), dec_mask_o, VEC[i].xmask);
      chk($sformatf("R7 R11 vec%0d prio", i), dec_prio_o, VEC[i].xprio);
      chk($sformatf("R11 vec%0d drop", i), dec_drop_o, VEC[i].xdrop);
      chk($sformatf("R6 R11 vec%0d push", i), uq_push_o, VEC[i].xpush);
    end

    @(negedge clk);
    chk("R9 valid drops when idle", dec_valid_o, 0);

    dec_ready_i = 0;
    apply(VEC[7]);
    @(negedge clk);
    req_valid_i = 0;
    chk("R6 stall push first cycle", uq_push_o, 1);
    chk("R9 ready low in stall", req_ready_o, 0);
    apply(VEC[0]);
    @(negedge clk);
    req_valid_i = 0;
    chk("R6 push single cycle", uq_push_o, 0);
    chk("R9 held valid", dec_valid_o, 1);
    chk("R9 held drop", dec_drop_o, 1);
    chk("R9 held prio", dec_prio_o, 5);
    chk("R9 held mask", dec_mask_o, 0);
    dec_ready_i = 1;
    @(negedge clk);
    chk("R9 released", dec_valid_o, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule